// File: doc/BRIEF.md
# Write-Through Snooping Cache Line Controller

This block manages coherence for a small direct-mapped, write-through cache that sits on a shared snooping bus. Each line holds one data word, a tag and a single valid bit. A line is therefore either Invalid or Valid. Processor loads that hit are answered from the local array in the same cycle. Loads that miss fetch the word over the bus and install it. Every processor store is written through to the bus. A store also refreshes the local copy when the line already holds that address. A store never installs a line.

The controller also watches write traffic from other bus agents. When another agent writes an address that a Valid line holds, that line is dropped to Invalid, so the next local load fetches fresh data. Each agent drives a requester identifier. The controller compares the snooped identifier with its own and ignores its own traffic.

The processor keeps `cpu_req` high until it sees a one-cycle `cpu_ready` pulse. Any operation that needs the bus raises `bus_req` and holds it until `bus_gnt`. It then waits for `bus_done` before it answers.

Top module: `wtc_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, so the first load of any address issues a bus read.
- R2: The address is split as index = `addr[IDX_W-1:0]` and tag = `addr[ADDR_W-1:IDX_W]`. A hit needs the indexed line to be Valid and its stored tag to equal the address tag.
- R3: A load hit raises `cpu_ready` in the cycle the request is presented, returns the stored word, and issues no bus transaction.
- R4: A load miss issues exactly one bus read (`bus_we`=0) for the requested address. It returns `bus_rdata` to the processor and leaves the line Valid with the new tag, so a repeat load hits.
- R5: Every store issues exactly one bus write (`bus_we`=1) that carries the store address and data, whether the line hit or missed.
- R6: A store hit updates the cached word. A store miss leaves the indexed line unchanged and does not allocate, so a later load of the stored address misses.
- R7: A snooped write (`snp_we`=1) from an identifier other than `MY_ID` whose address matches a Valid line makes that line Invalid.
- R8: A snooped read, a snooped write carrying `MY_ID`, or a snooped write whose tag differs from the line's tag leaves the line as it was.
- R9: Once `bus_req` is raised it stays high until `bus_gnt`. `cpu_ready` stays low until the cycle after `bus_done`. A bus operation is answered exactly three cycles plus the grant latency after the request.
- R10: A load miss to an index that holds a different tag replaces that line, so the address it held misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request, held until grant |
| bus_we | output | 1 | Bus command: 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_id | output | ID_W | Requester identifier of this controller |
| bus_gnt | input | 1 | One-cycle grant |
| bus_done | input | 1 | One-cycle completion; read data valid |
| bus_rdata | input | DATA_W | Bus read data |
| snp_valid | input | 1 | Snooped transaction present |
| snp_we | input | 1 | Snooped command: 1 = write |
| snp_addr | input | ADDR_W | Snooped address |
| snp_id | input | ID_W | Requester identifier of the snooped transaction |

## Verification
A wrong valid bit or tag does not show up when it goes wrong. It shows up on the next load of that index. A stale Valid line returns an old word in zero wait cycles with no bus read. A line wrongly left Invalid turns an expected zero-wait hit into a bus read that takes three cycles plus the grant latency. The bench therefore follows every store, snoop and alias access with a load. It checks both the returned word and the wait-cycle count against a count of bus reads. A fill or data-write enable on the wrong line appears as a wrong word on the neighbouring index in the same sweep.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } wtc_state_e;

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5,
  parameter int ID_W  = 2,
  parameter int MY_ID = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             snp_valid,
  input  logic             snp_we,
  input  logic [ID_W-1:0]  snp_id,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             snp_kill
);
  localparam int LINES = 1 << IDX_W;

  logic             valid_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  function automatic logic tag_match(input logic v, input logic [TAG_W-1:0] a,
                                     input logic [TAG_W-1:0] b);
    return v && (a == b);
  endfunction

  logic foreign_wr;
  logic fill_kill;

  assign lk_hit     = tag_match(valid_q[lk_idx], tag_q[lk_idx], lk_tag);
  assign foreign_wr = snp_valid && snp_we && (snp_id != ID_W'(MY_ID));
  assign snp_kill   = foreign_wr && tag_match(valid_q[snp_idx], tag_q[snp_idx], snp_tag);
  assign fill_kill  = foreign_wr && fill_en && (fill_idx == snp_idx) && (fill_tag == snp_tag);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic fill_sel;
    logic kill_sel;
    assign fill_sel = fill_en && (fill_idx == IDX_W'(i));
    assign kill_sel = snp_kill && (snp_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
      end else if (fill_sel) begin
        valid_q[i] <= !fill_kill;
        tag_q[i]   <= fill_tag;
      end else if (kill_sel) begin
        valid_q[i] <= 1'b0;
      end
    end
  end

  logic             kill_q;
  logic [IDX_W-1:0] kill_idx_q;
  logic [TAG_W-1:0] kill_tag_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kill_q     <= 1'b0;
      kill_idx_q <= '0;
      kill_tag_q <= '0;
    end else begin
      kill_q     <= snp_kill || fill_kill;
      kill_idx_q <= snp_idx;
      kill_tag_q <= snp_tag;
    end
  end

  // R7
  snoop_invalidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_q |-> !(valid_q[kill_idx_q] && (tag_q[kill_idx_q] == kill_tag_q)));

endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] word_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q[i] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        word_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_word,
  output logic              fill_en,
  output logic              dw_en,
  output logic [DATA_W-1:0] dw_data
);
  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  wtc_state_e        state_q, state_d;
  logic              op_we_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] lk_addr;
  logic              take_op;
  logic              idle_rd_hit;

  assign lk_addr     = (state_q == ST_IDLE) ? cpu_addr : op_addr_q;
  assign lk_idx      = addr_idx(lk_addr);
  assign lk_tag      = addr_tag(lk_addr);
  assign idle_rd_hit = (state_q == ST_IDLE) && cpu_req && !cpu_we && lk_hit;
  assign take_op     = (state_q == ST_IDLE) && cpu_req && !idle_rd_hit;

  assign bus_we    = op_we_q;
  assign bus_addr  = op_addr_q;
  assign bus_wdata = op_wdata_q;

  always_comb begin
    state_d   = state_q;
    cpu_ready = 1'b0;
    cpu_rdata = rdata_q;
    bus_req   = 1'b0;
    fill_en   = 1'b0;
    dw_en     = 1'b0;
    dw_data   = op_wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (idle_rd_hit) begin
          cpu_ready = 1'b1;
          cpu_rdata = lk_word;
        end else if (take_op) begin
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        bus_req = 1'b1;
        if (bus_gnt) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (bus_done) begin
          state_d = ST_RESP;
          if (!op_we_q) begin
            fill_en = 1'b1;
            dw_en   = 1'b1;
            dw_data = bus_rdata;
          end else if (lk_hit) begin
            dw_en = 1'b1;
          end
        end
      end
      ST_RESP: begin
        cpu_ready = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_we_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      rdata_q    <= '0;
    end else begin
      state_q <= state_d;
      if (take_op) begin
        op_we_q    <= cpu_we;
        op_addr_q  <= cpu_addr;
        op_wdata_q <= cpu_wdata;
      end
      if (state_q == ST_WAIT && bus_done && !op_we_q) rdata_q <= bus_rdata;
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  // R9
  no_early_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ || state_q == ST_WAIT) |-> !cpu_ready);

  // R5
  store_to_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && cpu_req && cpu_we) |=> (bus_req && bus_we));

  // R3
  hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_rd_hit |=> !bus_req);

  // R6
  store_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en || dw_en) |-> (!op_we_q ? fill_en : lk_hit));

endmodule

// File: rtl/wtc_snoop_cache.sv
module wtc_snoop_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [ID_W-1:0]   bus_id,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_word;
  logic              fill_en;
  logic              dw_en;
  logic [DATA_W-1:0] dw_data;
  logic              snp_kill;

  assign bus_id = ID_W'(MY_ID);

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_word(lk_word),
    .fill_en(fill_en), .dw_en(dw_en), .dw_data(dw_data)
  );

  wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .fill_en(fill_en), .fill_idx(lk_idx), .fill_tag(lk_tag),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_id(snp_id),
    .snp_idx(snp_addr[IDX_W-1:0]), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .snp_kill(snp_kill)
  );

  wtc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dw_en), .wr_idx(lk_idx), .wr_data(dw_data),
    .rd_idx(lk_idx), .rd_data(lk_word)
  );

  // R8
  own_snoop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_id == ID_W'(MY_ID) || !snp_we)) |-> !snp_kill);

endmodule

// File: tb/sim_wtc_snoop_cache.sv
`timescale 1ns/1ps
module sim_wtc_snoop_cache;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int IDW = 2;
  localparam int ME = 1;
  localparam int LINES = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [IDW-1:0] bus_id;
  logic bus_gnt = 0, bus_done = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 0, snp_we = 0;
  logic [AW-1:0] snp_addr = '0;
  logic [IDW-1:0] snp_id = '0;

  wtc_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .ID_W(IDW), .MY_ID(ME)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_id(bus_id), .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr), .snp_id(snp_id)
  );

  int n_chk = 0, n_bad = 0;
  int n_rd = 0, n_wr = 0;
  int lat = 1;
  logic [DW-1:0] mem [1 << AW];

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // bus and memory model; grant after lat cycles, completion one cycle later
  initial begin
    for (int a = 0; a < (1 << AW); a++) mem[a] = DW'(a * 37 + 5);
    forever begin
      @(negedge clk);
      if (bus_req === 1'b1) begin
        check("R5 bus id", int'(bus_id), ME);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          check("R9 req held before grant", int'(bus_req), 1);
        end
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        bus_done = 1'b1;
        bus_rdata = mem[bus_addr];
        if (bus_we) begin
          mem[bus_addr] = bus_wdata;
          n_wr++;
        end else begin
          n_rd++;
        end
        @(negedge clk);
        bus_done = 1'b0;
      end
    end
  end

  task automatic access(input logic we, input int addr, input int wdata,
                        output int rdata, output int waits);
    @(negedge clk);
    cpu_req = 1'b1;
    cpu_we = we;
    cpu_addr = AW'(addr);
    cpu_wdata = DW'(wdata);
    waits = 0;
    #1;
    while (cpu_ready !== 1'b1) begin
      @(negedge clk);
      waits++;
      #1;
    end
    rdata = int'(cpu_rdata);
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic we, input int addr, input int id);
    @(negedge clk);
    snp_valid = 1'b1;
    snp_we = we;
    snp_addr = AW'(addr);
    snp_id = IDW'(id);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  // load and confirm hit/miss plus data
  task automatic load_expect(input string req, input int addr, input bit miss);
    int d, w, r0, exp_w;
    r0 = n_rd;
    exp_w = miss ? lat + 3 : 0;
    access(1'b0, addr, 0, d, w);
    check({req, " data"}, d, int'(mem[addr]));
    check({req, " waits"}, w, exp_w);
    check({req, " bus reads"}, n_rd - r0, miss ? 1 : 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int d, w, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset ready low", int'(cpu_ready), 0);
    check("R1 reset no bus req", int'(bus_req), 0);

    // R1 R4: cold misses everywhere
    for (int a = 0; a < LINES; a++) begin
      lat = a % 3;
      load_expect("R1 R4 cold miss", a, 1'b1);
    end
    // R3 R2: repeat loads hit
    for (int a = 0; a < LINES; a++) load_expect("R3 R2 hit", a, 1'b0);

    // R5 R6: store hit writes through and updates line
    for (int a = 0; a < LINES; a++) begin
      lat = (a + 1) % 3;
      w0 = n_wr;
      access(1'b1, a, 16'hA000 + a, d, w);
      check("R5 store bus write", n_wr - w0, 1);
      check("R9 store waits", w, lat + 3);
      check("R5 store data at memory", int'(mem[a]), 16'hA000 + a);
      load_expect("R6 store hit updates", a, 1'b0);
    end

    // R6 R10: alias stores miss without allocation, alias loads replace
    for (int a = 0; a < LINES; a++) begin
      int al;
      al = a ^ LINES;
      w0 = n_wr;
      access(1'b1, al, 16'hB000 + a, d, w);
      check("R5 store miss bus write", n_wr - w0, 1);
      load_expect("R6 no allocate, old line kept", a, 1'b0);
      load_expect("R6 stored alias misses", al, 1'b1);
      load_expect("R10 replaced line misses", a, 1'b1);
    end

    // R7 R8: snoops
    for (int a = 0; a < LINES; a++) begin
      snoop(1'b1, a, ME);
      load_expect("R8 own snoop ignored", a, 1'b0);
      snoop(1'b0, a, (ME + 1) % 4);
      load_expect("R8 snooped read ignored", a, 1'b0);
      snoop(1'b1, a ^ LINES, (ME + 2) % 4);
      load_expect("R8 tag mismatch ignored", a, 1'b0);
      for (int id = 0; id < 4; id++) begin
        if (id != ME) begin
          snoop(1'b1, a, id);
          load_expect("R7 foreign write invalidates", a, 1'b1);
        end
      end
    end
    // R7: neighbours unaffected by one invalidation
    snoop(1'b1, 2, 0);
    load_expect("R7 neighbour kept", 1, 1'b0);
    load_expect("R7 target dropped", 2, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule